// File: doc/BRIEF.md
# Nested Stack Frame Copier

This block carries out the nested-level part of a stack-frame-enter operation. A start pulse supplies a nesting level, an operand-size code, the current stack pointer, the current frame pointer, a stack segment base, a stack address mask and a frame temporary value.

The block first reserves one slot on the stack. It then walks the previous frame: each saved frame pointer is read through a working copy of the frame pointer and written through the stack pointer. Last, it pushes the supplied temporary value. It finishes with a one-cycle done pulse and presents the resulting stack pointer.

Memory is reached through one read channel and one write channel, each with a request and ready handshake. Only one transaction is in flight at any time. Allocating locals, writing the final frame pointer and any fault checking are left to the surrounding logic.

Top module: `frame_copy_seq`

## Requirements
- R1: A start pulse in the idle state captures all inputs. Before any copy, the stack pointer is lowered once by the operand size. The first write therefore targets stack pointer minus two operand sizes.
- R2: Mode code 0 selects 2-byte operands, code 2 selects 8-byte operands, and codes 1 and 3 select 4-byte operands. `mem_bytes` shows the operand size during every request.
- R3: For a level L greater than 1, the block makes L-1 copy iterations. Iteration i reads at frame pointer minus i operand sizes and then writes at stack pointer minus (i+1) operand sizes. The written data is the read data truncated to the operand size, with the upper bits zero.
- R4: In modes 0, 1 and 3, every memory address is the segment base plus (the 32-bit pointer AND the mask). The mask is applied before the base is added, and the sum is taken modulo 2^64.
- R5: In mode 2, the raw 64-bit pointer is the address, with neither base nor mask.
- R6: In modes 0, 1 and 3, only the low 32 bits of the pointers are used. Pointer arithmetic wraps modulo 2^32, and the upper 32 bits of the result are zero.
- R7: A level of 0 or 1 performs no copy iteration. Only the reservation and the final push occur, so the single write lands at stack pointer minus two operand sizes.
- R8: After the copies, the stack pointer is lowered once more. The temporary value, truncated to the operand size, is written there.
- R9: Read and write requests are never raised together. A request is held, with its address and data stable, until its ready is seen. Each copy read completes before its write is requested.
- R10: `done` is high for exactly one cycle, the cycle after the final write handshake. `sp_out` then equals the starting stack pointer minus (max(L,1)+1) operand sizes.
- R11: A start pulse while an operation is running is ignored. The running operation continues with the inputs captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| level | input | LVL_W | Nesting level |
| mode | input | 2 | Operand-size code |
| sp_in | input | 64 | Starting stack pointer |
| fp_in | input | 64 | Starting frame pointer |
| seg_base | input | 64 | Stack segment base |
| sp_mask | input | 32 | Stack address mask |
| tmp_val | input | 64 | Frame temporary value pushed last |
| rd_req | output | 1 | Read request |
| rd_addr | output | 64 | Read address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | 64 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Write data, truncated to the operand size |
| wr_ready | input | 1 | Write accepted |
| mem_bytes | output | 4 | Operand size in bytes |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 64 | Current and final stack pointer |

## Verification
The assertions take two things for granted. First, rd_data is meaningful only in a cycle where rd_ready is high. Second, ready is never raised without a matching request. The bench's memory responder grants only a pending request, after a wait of zero to two cycles, and returns an address-derived word in the grant cycle. It drives start only at the beginning of each run, plus one deliberate pulse during certain running operations, so the idle-only acceptance rule is the only thing that keeps a second operation from starting.

// File: rtl/frame_copy_pkg.sv
package frame_copy_pkg;
  localparam int FC_PTR_W  = 64;
  localparam int FC_NAR_W  = 32;
  localparam int FC_DATA_W = 64;
  localparam int FC_SIZE_W = 4;
  localparam int FC_HALF_W = 16;

  typedef enum logic [1:0] {
    OPW_16  = 2'd0,
    OPW_32  = 2'd1,
    OPW_64  = 2'd2,
    OPW_32B = 2'd3
  } opw_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STEP  = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_LAST  = 3'd4,
    S_PUSH  = 3'd5
  } fc_state_e;

  // operand size in bytes for a mode code
  function automatic logic [FC_SIZE_W-1:0] opw_bytes(opw_e m);
    case (m)
      OPW_16:  return FC_SIZE_W'(2);
      OPW_64:  return FC_SIZE_W'(8);
      default: return FC_SIZE_W'(4);
    endcase
  endfunction

  // narrow modes keep only the low pointer bits
  function automatic logic [FC_PTR_W-1:0] ptr_fold(logic [FC_PTR_W-1:0] p, opw_e m);
    if (m == OPW_64) return p;
    return {{(FC_PTR_W-FC_NAR_W){1'b0}}, p[FC_NAR_W-1:0]};
  endfunction

  // lower a pointer by one operand, wrapping at the mode's width
  function automatic logic [FC_PTR_W-1:0] ptr_step(logic [FC_PTR_W-1:0] p, opw_e m);
    logic [FC_PTR_W-1:0] dec;
    dec = {{(FC_PTR_W-FC_SIZE_W){1'b0}}, opw_bytes(m)};
    return ptr_fold(p - dec, m);
  endfunction

  // pointer to memory address
  function automatic logic [FC_PTR_W-1:0] form_addr(logic [FC_PTR_W-1:0] p,
                                                    logic [FC_PTR_W-1:0] base,
                                                    logic [FC_NAR_W-1:0] mask,
                                                    opw_e m);
    if (m == OPW_64) return p;
    return base + {{(FC_PTR_W-FC_NAR_W){1'b0}}, p[FC_NAR_W-1:0] & mask};
  endfunction

  // clip a data word to the operand size
  function automatic logic [FC_DATA_W-1:0] data_fit(logic [FC_DATA_W-1:0] d, opw_e m);
    case (m)
      OPW_16:  return {{(FC_DATA_W-FC_HALF_W){1'b0}}, d[FC_HALF_W-1:0]};
      OPW_64:  return d;
      default: return {{(FC_DATA_W-FC_NAR_W){1'b0}}, d[FC_NAR_W-1:0]};
    endcase
  endfunction
endpackage

// File: rtl/frame_copy_fsm.sv
module frame_copy_fsm
  import frame_copy_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LVL_W-1:0] level,
  input  logic             rd_fire,
  input  logic             wr_fire,
  output fc_state_e        st,
  output logic             load_ev,
  output logic             step_ev,
  output logic             last_ev,
  output logic             done
);
  fc_state_e        st_q, st_d;
  logic [LVL_W-1:0] left_q;
  logic             multi;

  assign multi = (level > LVL_W'(1));
  assign st    = st_q;

  always_comb begin
    st_d    = st_q;
    load_ev = 1'b0;
    step_ev = 1'b0;
    last_ev = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        load_ev = 1'b1;
        st_d    = multi ? S_STEP : S_LAST;
      end
      S_STEP: begin
        step_ev = 1'b1;
        st_d    = S_READ;
      end
      S_READ:  if (rd_fire) st_d = S_WRITE;
      S_WRITE: if (wr_fire) st_d = (left_q == LVL_W'(1)) ? S_LAST : S_STEP;
      S_LAST: begin
        last_ev = 1'b1;
        st_d    = S_PUSH;
      end
      S_PUSH:  if (wr_fire) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= (st_q == S_PUSH) && wr_fire;
      if (load_ev)
        left_q <= multi ? level - LVL_W'(1) : '0;
      else if ((st_q == S_WRITE) && wr_fire)
        left_q <= left_q - LVL_W'(1);
    end
  end
endmodule

// File: rtl/frame_copy_ptrs.sv
module frame_copy_ptrs
  import frame_copy_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_ev,
  input  logic                step_ev,
  input  logic                last_ev,
  input  opw_e                mode_in,
  input  opw_e                mode_q,
  input  logic [FC_PTR_W-1:0] sp_in,
  input  logic [FC_PTR_W-1:0] fp_in,
  output logic [FC_PTR_W-1:0] sp_q,
  output logic [FC_PTR_W-1:0] fp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      fp_q <= '0;
    end else if (load_ev) begin
      sp_q <= ptr_step(sp_in, mode_in);
      fp_q <= ptr_fold(fp_in, mode_in);
    end else if (step_ev) begin
      sp_q <= ptr_step(sp_q, mode_q);
      fp_q <= ptr_step(fp_q, mode_q);
    end else if (last_ev) begin
      sp_q <= ptr_step(sp_q, mode_q);
    end
  end
endmodule

// File: rtl/frame_copy_mem.sv
module frame_copy_mem
  import frame_copy_pkg::*;
(
  input  fc_state_e              st,
  input  opw_e                   mode_q,
  input  logic [FC_PTR_W-1:0]    sp_q,
  input  logic [FC_PTR_W-1:0]    fp_q,
  input  logic [FC_PTR_W-1:0]    base_q,
  input  logic [FC_NAR_W-1:0]    mask_q,
  input  logic [FC_DATA_W-1:0]   tmp_q,
  input  logic [FC_DATA_W-1:0]   copy_q,
  output logic                   rd_req,
  output logic [FC_PTR_W-1:0]    rd_addr,
  output logic                   wr_req,
  output logic [FC_PTR_W-1:0]    wr_addr,
  output logic [FC_DATA_W-1:0]   wr_data,
  output logic [FC_SIZE_W-1:0]   mem_bytes
);
  always_comb begin
    rd_req    = (st == S_READ);
    wr_req    = (st == S_WRITE) || (st == S_PUSH);
    rd_addr   = form_addr(fp_q, base_q, mask_q, mode_q);
    wr_addr   = form_addr(sp_q, base_q, mask_q, mode_q);
    wr_data   = (st == S_PUSH) ? data_fit(tmp_q, mode_q) : copy_q;
    mem_bytes = opw_bytes(mode_q);
  end
endmodule

// File: rtl/frame_copy_seq.sv
module frame_copy_seq
  import frame_copy_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LVL_W-1:0]     level,
  input  logic [1:0]           mode,
  input  logic [FC_PTR_W-1:0]  sp_in,
  input  logic [FC_PTR_W-1:0]  fp_in,
  input  logic [FC_PTR_W-1:0]  seg_base,
  input  logic [FC_NAR_W-1:0]  sp_mask,
  input  logic [FC_DATA_W-1:0] tmp_val,
  output logic                 rd_req,
  output logic [FC_PTR_W-1:0]  rd_addr,
  input  logic                 rd_ready,
  input  logic [FC_DATA_W-1:0] rd_data,
  output logic                 wr_req,
  output logic [FC_PTR_W-1:0]  wr_addr,
  output logic [FC_DATA_W-1:0] wr_data,
  input  logic                 wr_ready,
  output logic [FC_SIZE_W-1:0] mem_bytes,
  output logic                 done,
  output logic [FC_PTR_W-1:0]  sp_out
);
  fc_state_e             st;
  opw_e                  mode_in, mode_q;
  logic                  load_ev, step_ev, last_ev;
  logic                  rd_fire, wr_fire;
  logic [FC_PTR_W-1:0]   sp_q, fp_q, base_q;
  logic [FC_NAR_W-1:0]   mask_q;
  logic [FC_DATA_W-1:0]  tmp_q, copy_q;

  assign mode_in = opw_e'(mode);
  assign rd_fire = rd_req && rd_ready;
  assign wr_fire = wr_req && wr_ready;
  assign sp_out  = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= OPW_16;
      base_q <= '0;
      mask_q <= '0;
      tmp_q  <= '0;
      copy_q <= '0;
    end else begin
      if (load_ev) begin
        mode_q <= mode_in;
        base_q <= seg_base;
        mask_q <= sp_mask;
        tmp_q  <= tmp_val;
      end
      if (rd_fire) copy_q <= data_fit(rd_data, mode_q);
    end
  end

  frame_copy_fsm #(.LVL_W(LVL_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .st(st),
    .load_ev(load_ev), .step_ev(step_ev), .last_ev(last_ev), .done(done)
  );

  frame_copy_ptrs ptrs_i (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .step_ev(step_ev),
    .last_ev(last_ev), .mode_in(mode_in), .mode_q(mode_q),
    .sp_in(sp_in), .fp_in(fp_in), .sp_q(sp_q), .fp_q(fp_q)
  );

  frame_copy_mem mem_i (
    .st(st), .mode_q(mode_q), .sp_q(sp_q), .fp_q(fp_q), .base_q(base_q),
    .mask_q(mask_q), .tmp_q(tmp_q), .copy_q(copy_q),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .mem_bytes(mem_bytes)
  );
endmodule

// File: rtl/frame_copy_sva.sv
module frame_copy_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_ready,
  input logic [63:0] rd_addr,
  input logic        wr_req,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [63:0] wr_data,
  input logic [3:0]  mem_bytes,
  input logic        done,
  input logic        rd_fire,
  input logic        wr_fire
);
  assert_one_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> wr_req);

  assert_size_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> ($countones(mem_bytes) == 1 && mem_bytes != 4'd1));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_fire));
endmodule

bind frame_copy_seq frame_copy_sva sva_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .wr_req(wr_req), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .mem_bytes(mem_bytes), .done(done),
  .rd_fire(rd_fire), .wr_fire(wr_fire)
);

// File: tb/frame_copy_seq_tb_top.sv
`timescale 1ns/1ps
module frame_copy_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  level = '0;
  logic [1:0]  mode = '0;
  logic [63:0] sp_in = '0, fp_in = '0, seg_base = '0, tmp_val = '0;
  logic [31:0] sp_mask = '0;
  logic        rd_req, wr_req, done;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [63:0] rd_addr, wr_addr, wr_data, sp_out;
  logic [63:0] rd_data = '0;
  logic [3:0]  mem_bytes;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int runid = 0;
  int idx = 0, n_exp = 0, wcnt = 0, fin_cyc = -10;
  bit          exp_wr [0:63];
  logic [63:0] exp_addr [0:63];
  logic [63:0] exp_data [0:63];
  logic [3:0]  exp_sz = 4'd2;
  string       tag_addr = "R4";

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_copy_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .mode(mode),
    .sp_in(sp_in), .fp_in(fp_in), .seg_base(seg_base), .sp_mask(sp_mask),
    .tmp_val(tmp_val), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .mem_bytes(mem_bytes), .done(done), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] memf(logic [63:0] a);
    return {a[31:0] ^ 32'h5A3C_96E1, a[63:32] + a[31:0]};
  endfunction

  // memory responder: grants after 0..2 wait cycles, checks each transaction
  always @(negedge clk) begin
    rd_ready = 1'b0;
    wr_ready = 1'b0;
    if (!rst_n) begin
      wcnt = 0;
    end else begin
      if (rd_req && wr_req) chk(1'b0, "R9", "both requests high", 64'd1, 64'd0);
      if (rd_req || wr_req) begin
        if (wcnt >= (idx + runid) % 3) begin
          wcnt = 0;
          chk(mem_bytes == exp_sz, "R2", "operand size", 64'(mem_bytes), 64'(exp_sz));
          if (idx >= n_exp) begin
            chk(1'b0, "R3", "extra transaction", 64'(idx), 64'(n_exp));
          end else if (rd_req) begin
            chk(!exp_wr[idx], "R9", "read where write due", 64'd1, 64'd0);
            chk(rd_addr == exp_addr[idx], tag_addr, "read address", rd_addr, exp_addr[idx]);
            rd_data  = memf(rd_addr);
            rd_ready = 1'b1;
            idx++;
          end else begin
            chk(exp_wr[idx], "R9", "write where read due", 64'd0, 64'd1);
            chk(wr_addr == exp_addr[idx], (idx == 1) ? "R1" : tag_addr,
                "write address", wr_addr, exp_addr[idx]);
            chk(wr_data == exp_data[idx], (idx == n_exp - 1) ? "R8" : "R3",
                "write data", wr_data, exp_data[idx]);
            if (idx == n_exp - 1) fin_cyc = cyc;
            wr_ready = 1'b1;
            idx++;
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  function automatic logic [63:0] eptr(logic [63:0] p, int k, logic [1:0] md, logic [3:0] sz);
    logic [63:0] d;
    d = 64'(k) * 64'(sz);
    if (md == 2'd2) return p - d;
    return {32'd0, p[31:0] - d[31:0]};
  endfunction

  function automatic logic [63:0] eaddr(logic [63:0] p, logic [63:0] b, logic [31:0] m,
                                        logic [1:0] md);
    if (md == 2'd2) return p;
    return b + {32'd0, p[31:0] & m};
  endfunction

  function automatic logic [63:0] efit(logic [63:0] d, logic [1:0] md);
    if (md == 2'd0) return d & 64'h0000_0000_0000_FFFF;
    if (md == 2'd2) return d;
    return d & 64'h0000_0000_FFFF_FFFF;
  endfunction

  task automatic run(input logic [3:0] lv, input logic [1:0] md, input logic [63:0] sp0,
                     input logic [63:0] fp0, input logic [63:0] b, input logic [31:0] m,
                     input logic [63:0] tv, input bit inject);
    int L;
    bit seen;
    logic [63:0] ra, exp_sp;
    L = (lv < 1) ? 1 : int'(lv);
    exp_sz = (md == 2'd0) ? 4'd2 : (md == 2'd2) ? 4'd8 : 4'd4;
    tag_addr = (md == 2'd2) ? "R5" : "R4";
    n_exp = 0;
    for (int i = 1; i < L; i++) begin
      ra = eaddr(eptr(fp0, i, md, exp_sz), b, m, md);
      exp_wr[n_exp] = 1'b0; exp_addr[n_exp] = ra; exp_data[n_exp] = '0; n_exp++;
      exp_wr[n_exp] = 1'b1; exp_addr[n_exp] = eaddr(eptr(sp0, i + 1, md, exp_sz), b, m, md);
      exp_data[n_exp] = efit(memf(ra), md); n_exp++;
    end
    exp_wr[n_exp] = 1'b1; exp_addr[n_exp] = eaddr(eptr(sp0, L + 1, md, exp_sz), b, m, md);
    exp_data[n_exp] = efit(tv, md); n_exp++;
    exp_sp = eptr(sp0, L + 1, md, exp_sz);
    idx = 0; fin_cyc = -10; runid++;

    @(negedge clk);
    level = lv; mode = md; sp_in = sp0; fp_in = fp0; seg_base = b; sp_mask = m;
    tv = tv; tmp_val = tv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int t = 2; t < 400 && !seen; t++) begin
      @(negedge clk);
      if (t == 2 && inject) begin
        // R11: start while busy, with different inputs
        start = 1'b1; level = 4'd7; mode = ~md; sp_in = ~sp0; fp_in = ~fp0;
        seg_base = ~b; tmp_val = ~tv;
      end else if (t == 3) begin
        start = 1'b0;
      end
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk(seen, "R10", "done seen", 64'(seen), 64'd1);
    if (seen) begin
      chk(cyc == fin_cyc + 1, "R10", "done one cycle after final write",
          64'(cyc), 64'(fin_cyc + 1));
      chk(sp_out == exp_sp, (md == 2'd2) ? "R10" : "R6", "final stack pointer",
          sp_out, exp_sp);
      chk(idx == n_exp, (lv <= 1) ? "R7" : "R3", "transaction count",
          64'(idx), 64'(n_exp));
      @(negedge clk);
      chk(!done, "R10", "done pulse width", 64'(done), 64'd0);
      chk(!rd_req && !wr_req, "R11", "no request after done",
          64'({rd_req, wr_req}), 64'd0);
    end
  endtask

  initial begin
    #(64'd200000 * 64'd20);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] sps [0:2];
    logic [63:0] fps [0:2];
    logic [63:0] bas [0:2];
    logic [31:0] msk [0:2];
    sps[0] = 64'h0000_0000_0000_1000; fps[0] = 64'h0000_0000_0000_1040;
    bas[0] = 64'h0000_0001_0000_0000; msk[0] = 32'hFFFF_FFFF;
    sps[1] = 64'h0000_0000_0000_0006; fps[1] = 64'h0000_0000_0000_0004;
    bas[1] = 64'h0000_0001_2345_0000; msk[1] = 32'h0000_FFFF;
    sps[2] = 64'hFFFF_0000_0000_2000; fps[2] = 64'hFFFF_0000_0000_1FF8;
    bas[2] = 64'h0000_0000_0000_0000; msk[2] = 32'h0000_0FFF;

    repeat (3) @(negedge clk);
    chk(!done && !rd_req && !wr_req, "R10", "reset outputs idle",
        64'({done, rd_req, wr_req}), 64'd0);
    chk(sp_out == 64'd0, "R10", "reset stack pointer", sp_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int md = 0; md < 4; md++)
      for (int lv = 0; lv < 6; lv++)
        for (int s = 0; s < 3; s++)
          run(4'(lv), 2'(md), sps[s], fps[s], bas[s], msk[s],
              64'hF1E2_D3C4_B5A6_9788 ^ 64'(md * 16 + lv), lv == 3);
    run(4'd9, 2'd1, sps[0], fps[0], bas[0], msk[0], 64'h1234_5678_9ABC_DEF0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule